// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash. On a start request it either writes a run of bytes, taken one at a time from a source buffer, into consecutive flash addresses, or it wipes the whole device. For every byte it sends the three-cycle unlock-and-program preamble, writes the byte, and then polls the device until the embedded operation has ended. A chip wipe uses the six-cycle erase sequence and is polled the same way.

Completion is read from status bits, not waited out with a fixed delay. The host picks one of two polling methods: comparing the top data bit against the written value, or watching a status bit that alternates on every read while the device is busy. When the device raises its time-limit-exceeded flag, the block always reads the device again before it gives a verdict. A poll-count limit ends a poll that never resolves. On any failure the block sends a single reset write to the device, records the address that failed and finishes with pass low.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Each byte is written with exactly four bus writes in this order: data AAh at address 555h, data 55h at address 2AAh, data A0h at address 555h, then the source byte at base plus byte index.
- R2: In bit-compare polling, a status read whose bit 7 equals bit 7 of the written byte ends that byte as passed. Two status reads are never issued in back-to-back cycles.
- R3: In bit-compare polling, a mismatching read with bit 5 low polls again. A mismatching read with bit 5 high causes one more read, which passes if bit 7 now matches and fails otherwise.
- R4: In alternating-bit polling, two successive reads with equal bit 6 end the operation as passed. If bit 6 differs and bit 5 is low, a new pair of reads starts.
- R5: In alternating-bit polling, if bit 6 differs and bit 5 is high, two further reads are made. The result fails if their bit 6 differs and passes otherwise.
- R6: Bytes go to base, base+1, and so on up to base+len-1. After the last byte, done is high for exactly one cycle with pass high. A program request with len 0 completes with pass high and no bus writes.
- R7: A chip wipe issues the six writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h, then polls with the alternating-bit method whatever method was selected.
- R8: When POLL_LIMIT polls in a row end with neither a verdict nor bit 5 seen, the operation fails.
- R9: On failure, exactly one write of F0h is issued, fail_addr holds the address that was being polled, and pass is low at done.
- R10: During and after reset the block is idle: busy, done, fl_we and fl_re are low.
- R11: A start request is ignored while busy is high.
- R12: fl_we and fl_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start pulse, sampled while idle |
| req_erase | input | 1 | 1 = wipe the whole chip, 0 = program a run of bytes |
| req_toggle | input | 1 | 1 = alternating-bit polling, 0 = bit-compare polling |
| req_base | input | AW | First flash address |
| req_len | input | AW+1 | Number of bytes to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last operation |
| fail_addr | output | AW | Address polled when the last failure occurred |
| src_idx | output | AW | Index of the source byte being requested |
| src_data | input | 8 | Source byte at src_idx, combinational |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus read strobe |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | 8 | Flash bus write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after fl_re |

## Verification
The bench builds the block with AW set to 12 and POLL_LIMIT set to 8. A 12-bit address still holds both unlock addresses. The small poll limit lets a device model that never finishes reach watchdog expiry within a few dozen cycles, where the default limit would need hundreds of thousands. The model can be stalled at a chosen address, can raise bit 5 after a chosen number of reads, and can finish just as the recheck read arrives, so both recheck outcomes of each polling method occur.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_RD,
      ST_EV,
      ST_RST,
      ST_DONE
   } st_t;

   typedef enum logic [1:0] {
      PH_FIRST,
      PH_SECOND,
      PH_RCHK1,
      PH_RCHK2
   } ph_t;

   typedef enum logic [1:0] {
      VD_RETRY,
      VD_NEXT,
      VD_PASS,
      VD_FAIL
   } vd_t;

   localparam logic [10:0] ADDR_HI_UNLOCK = 11'h555;
   localparam logic [10:0] ADDR_LO_UNLOCK = 11'h2AA;
   localparam logic [7:0]  KEY_FIRST      = 8'hAA;
   localparam logic [7:0]  KEY_SECOND     = 8'h55;
   localparam logic [7:0]  OP_PROGRAM     = 8'hA0;
   localparam logic [7:0]  OP_ERASE_SETUP = 8'h80;
   localparam logic [7:0]  OP_CHIP_WIPE   = 8'h10;
   localparam logic [7:0]  OP_RESET       = 8'hF0;

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
   import flash_prog_pkg::*;
#(
   parameter int unsigned AW = 17
) (
   input  logic          erase,
   input  logic [2:0]    step,
   input  logic [AW-1:0] tgt_addr,
   input  logic [7:0]    tgt_data,
   output logic [AW-1:0] addr,
   output logic [7:0]    data,
   output logic          last
);

   localparam logic [AW-1:0] A_HI = AW'(ADDR_HI_UNLOCK);
   localparam logic [AW-1:0] A_LO = AW'(ADDR_LO_UNLOCK);

   always_comb begin
      addr = A_HI;
      data = KEY_FIRST;
      last = 1'b0;
      if (erase) begin
         case (step)
            3'd0: begin addr = A_HI; data = KEY_FIRST;      end
            3'd1: begin addr = A_LO; data = KEY_SECOND;     end
            3'd2: begin addr = A_HI; data = OP_ERASE_SETUP; end
            3'd3: begin addr = A_HI; data = KEY_FIRST;      end
            3'd4: begin addr = A_LO; data = KEY_SECOND;     end
            3'd5: begin addr = A_HI; data = OP_CHIP_WIPE; last = 1'b1; end
            default: begin addr = A_HI; data = OP_CHIP_WIPE; last = 1'b1; end
         endcase
      end else begin
         case (step)
            3'd0: begin addr = A_HI; data = KEY_FIRST;  end
            3'd1: begin addr = A_LO; data = KEY_SECOND; end
            3'd2: begin addr = A_HI; data = OP_PROGRAM; end
            default: begin addr = tgt_addr; data = tgt_data; last = 1'b1; end
         endcase
      end
   end

endmodule

// File: rtl/flash_poll_judge.sv
module flash_poll_judge
   import flash_prog_pkg::*;
(
   input  logic toggle,
   input  ph_t  phase,
   input  logic rd7,
   input  logic rd6,
   input  logic rd5,
   input  logic exp7,
   input  logic prev6,
   output vd_t  verdict,
   output ph_t  nphase
);

   always_comb begin
      verdict = VD_RETRY;
      nphase  = PH_FIRST;
      if (!toggle) begin
         case (phase)
            PH_FIRST: begin
               if (rd7 == exp7)  verdict = VD_PASS;
               else if (rd5) begin
                  verdict = VD_NEXT;
                  nphase  = PH_RCHK1;
               end else verdict = VD_RETRY;
            end
            default: verdict = (rd7 == exp7) ? VD_PASS : VD_FAIL;
         endcase
      end else begin
         case (phase)
            PH_FIRST: begin
               verdict = VD_NEXT;
               nphase  = PH_SECOND;
            end
            PH_SECOND: begin
               if (rd6 == prev6) verdict = VD_PASS;
               else if (rd5) begin
                  verdict = VD_NEXT;
                  nphase  = PH_RCHK1;
               end else verdict = VD_RETRY;
            end
            PH_RCHK1: begin
               verdict = VD_NEXT;
               nphase  = PH_RCHK2;
            end
            default: verdict = (rd6 == prev6) ? VD_PASS : VD_FAIL;
         endcase
      end
   end

endmodule

// File: rtl/flash_poll_wdog.sv
module flash_poll_wdog #(
   parameter int unsigned LIMIT = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic expired
);

   generate
      if (LIMIT == 0) begin : g_off
         logic unused_wdog;
         assign unused_wdog = ^{clk, rst_n, clr, tick};
         assign expired     = 1'b0;
      end else begin : g_on
         localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (clr)  cnt <= '0;
            else if (tick) cnt <= cnt + 1'b1;
         end
         assign expired = tick && (cnt == CW'(LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import flash_prog_pkg::*;
#(
   parameter int unsigned AW         = 17,
   parameter int unsigned POLL_LIMIT = 200000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_erase,
   input  logic          req_toggle,
   input  logic [AW-1:0] req_base,
   input  logic [AW:0]   req_len,
   output logic          busy,
   output logic          done,
   output logic          pass,
   output logic [AW-1:0] fail_addr,
   output logic [AW-1:0] src_idx,
   input  logic [7:0]    src_data,
   output logic          fl_we,
   output logic          fl_re,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_wdata,
   input  logic [7:0]    fl_rdata
);

   generate
      if (AW < 12) begin : g_bad_aw
         $error("flash_prog_ctrl: AW must be at least 12");
      end
   endgenerate

   st_t           st;
   ph_t           phase;
   logic [2:0]    step;
   logic          erase_q;
   logic          toggle_q;
   logic [AW-1:0] base_q;
   logic [AW:0]   len_q;
   logic [AW:0]   idx;
   logic          prev6;
   logic          pass_q;
   logic [AW-1:0] fail_addr_q;

   logic [AW:0]   idx_nxt;
   logic [AW-1:0] cur_addr;
   logic [AW-1:0] poll_addr;
   logic [AW-1:0] cmd_addr;
   logic [7:0]    cmd_data;
   logic          cmd_last;
   logic          exp7;
   vd_t           verdict;
   vd_t           verdict_eff;
   ph_t           nphase;
   logic          wd_clr;
   logic          wd_tick;
   logic          wd_expired;
   logic          unused_rd;

   assign unused_rd = ^fl_rdata[4:0];
   assign idx_nxt   = idx + {{AW{1'b0}}, 1'b1};
   assign cur_addr  = base_q + idx[AW-1:0];
   assign poll_addr = erase_q ? base_q : cur_addr;
   assign exp7      = erase_q ? 1'b1 : src_data[7];

   flash_cmd_table #(.AW(AW)) u_cmd (
      .erase    (erase_q),
      .step     (step),
      .tgt_addr (cur_addr),
      .tgt_data (src_data),
      .addr     (cmd_addr),
      .data     (cmd_data),
      .last     (cmd_last)
   );

   flash_poll_judge u_judge (
      .toggle  (toggle_q | erase_q),
      .phase   (phase),
      .rd7     (fl_rdata[7]),
      .rd6     (fl_rdata[6]),
      .rd5     (fl_rdata[5]),
      .exp7    (exp7),
      .prev6   (prev6),
      .verdict (verdict),
      .nphase  (nphase)
   );

   assign wd_clr  = (st == ST_CMD) && cmd_last;
   assign wd_tick = (st == ST_EV) && (verdict == VD_RETRY);

   flash_poll_wdog #(.LIMIT(POLL_LIMIT)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (wd_clr),
      .tick    (wd_tick),
      .expired (wd_expired)
   );

   assign verdict_eff = (verdict == VD_RETRY && wd_expired) ? VD_FAIL : verdict;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         phase       <= PH_FIRST;
         step        <= '0;
         erase_q     <= 1'b0;
         toggle_q    <= 1'b0;
         base_q      <= '0;
         len_q       <= '0;
         idx         <= '0;
         prev6       <= 1'b0;
         pass_q      <= 1'b0;
         fail_addr_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  erase_q  <= req_erase;
                  toggle_q <= req_toggle;
                  base_q   <= req_base;
                  len_q    <= req_len;
                  idx      <= '0;
                  step     <= '0;
                  if (!req_erase && req_len == '0) begin
                     pass_q <= 1'b1;
                     st     <= ST_DONE;
                  end else begin
                     pass_q <= 1'b0;
                     st     <= ST_CMD;
                  end
               end
            end
            ST_CMD: begin
               if (cmd_last) begin
                  phase <= PH_FIRST;
                  st    <= ST_RD;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_RD: st <= ST_EV;
            ST_EV: begin
               prev6 <= fl_rdata[6];
               case (verdict_eff)
                  VD_PASS: begin
                     if (erase_q || idx_nxt == len_q) begin
                        pass_q <= 1'b1;
                        st     <= ST_DONE;
                     end else begin
                        idx  <= idx_nxt;
                        step <= '0;
                        st   <= ST_CMD;
                     end
                  end
                  VD_FAIL: begin
                     pass_q      <= 1'b0;
                     fail_addr_q <= poll_addr;
                     st          <= ST_RST;
                  end
                  VD_NEXT: begin
                     phase <= nphase;
                     st    <= ST_RD;
                  end
                  default: begin
                     phase <= PH_FIRST;
                     st    <= ST_RD;
                  end
               endcase
            end
            ST_RST:  st <= ST_DONE;
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_DONE);
   assign pass      = pass_q;
   assign fail_addr = fail_addr_q;
   assign src_idx   = idx[AW-1:0];
   assign fl_we     = (st == ST_CMD) || (st == ST_RST);
   assign fl_re     = (st == ST_RD);

   always_comb begin
      fl_addr  = poll_addr;
      fl_wdata = cmd_data;
      if (st == ST_CMD) begin
         fl_addr = cmd_addr;
      end else if (st == ST_RST) begin
         fl_addr  = '0;
         fl_wdata = OP_RESET;
      end
   end

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic done,
   input logic fl_we,
   input logic fl_re
);

   assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(fl_we || fl_re));

   assert_read_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fl_re |=> !fl_re);

   assert_start_on_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .fl_we     (fl_we),
   .fl_re     (fl_re)
);

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 12;
   localparam int LIM        = 8;
   localparam int NV         = 9;

   typedef struct packed {
      logic        erase;
      logic        tog;
      logic [11:0] base;
      logic [12:0] len;
      logic [7:0]  busy;
      logic [7:0]  dq5_at;
      logic [11:0] hang_addr;
      logic        exp_pass;
   } vec_t;

   // erase, tog, base, len, busy reads, dq5 after N reads (255 never), stalled address (FFF none), pass
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b0, 1'b0, 12'h010, 13'd4, 8'd2, 8'd255, 12'hFFF, 1'b1},  // R1 R2 R6
      '{1'b0, 1'b1, 12'h020, 13'd3, 8'd3, 8'd255, 12'hFFF, 1'b1},  // R4
      '{1'b0, 1'b0, 12'h005, 13'd2, 8'd3, 8'd2,   12'hFFF, 1'b1},  // R3 recheck passes
      '{1'b0, 1'b1, 12'h008, 13'd2, 8'd3, 8'd2,   12'hFFF, 1'b1},  // R5 late finish
      '{1'b0, 1'b0, 12'h030, 13'd3, 8'd1, 8'd0,   12'h031, 1'b0},  // R3 recheck fails, R9
      '{1'b0, 1'b1, 12'h018, 13'd2, 8'd1, 8'd0,   12'h018, 1'b0},  // R5 still toggling
      '{1'b0, 1'b0, 12'h028, 13'd2, 8'd1, 8'd255, 12'h029, 1'b0},  // R8 watchdog
      '{1'b1, 1'b0, 12'h000, 13'd0, 8'd5, 8'd255, 12'hFFF, 1'b1},  // R7
      '{1'b0, 1'b0, 12'h038, 13'd5, 8'd0, 8'd255, 12'hFFF, 1'b1}   // R2 instant
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_erase = 1'b0;
   logic          req_toggle = 1'b0;
   logic [AW-1:0] req_base = '0;
   logic [AW:0]   req_len = '0;
   logic          busy, done, pass;
   logic [AW-1:0] fail_addr, src_idx, fl_addr;
   logic [7:0]    src_data, fl_wdata;
   logic [7:0]    fl_rdata = 8'h00;
   logic          fl_we, fl_re;

   int checks = 0;
   int errors = 0;
   logic [7:0] seed = 8'h03;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] pat(input logic [AW-1:0] i, input logic [7:0] s);
      return i[7:0] * 8'd73 + s;
   endfunction

   assign src_data = pat(src_idx, seed);

   flash_prog_ctrl #(.AW(AW), .POLL_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
      .req_toggle(req_toggle), .req_base(req_base), .req_len(req_len),
      .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr),
      .src_idx(src_idx), .src_data(src_data), .fl_we(fl_we), .fl_re(fl_re),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
   );

   // ---------------- flash device model ----------------
   logic [7:0]  mem [0:63];
   int          cfg_busy = 0;
   int          cfg_dq5 = 255;
   logic [11:0] cfg_hang = 12'hFFF;
   int          ms = 0;
   int          busy_left = 0;
   bit          hang = 0;
   bit          tog = 0;
   int          rsince = 0;
   logic [7:0]  tgt = 8'h00;
   int          wr_cnt = 0;
   int          rst_cnt = 0;
   int          proto_err = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         if (fl_we) begin
            wr_cnt++;
            if (ms == 3 && busy_left == 0 && !hang) begin
               mem[fl_addr[5:0]] = fl_wdata;
               tgt       = fl_wdata;
               busy_left = cfg_busy;
               hang      = (fl_addr == cfg_hang);
               rsince    = 0;
               ms        = 0;
            end else if (fl_wdata == 8'hF0) begin
               ms = 0; busy_left = 0; hang = 0; rst_cnt++;
            end else if (busy_left != 0 || hang) begin
               proto_err++;
            end else begin
               case (ms)
                  0: if (fl_addr == 12'h555 && fl_wdata == 8'hAA) ms = 1; else begin proto_err++; ms = 0; end
                  1: if (fl_addr == 12'h2AA && fl_wdata == 8'h55) ms = 2; else begin proto_err++; ms = 0; end
                  2: if (fl_addr == 12'h555 && fl_wdata == 8'hA0) ms = 3;
                     else if (fl_addr == 12'h555 && fl_wdata == 8'h80) ms = 4;
                     else begin proto_err++; ms = 0; end
                  4: if (fl_addr == 12'h555 && fl_wdata == 8'hAA) ms = 5; else begin proto_err++; ms = 0; end
                  5: if (fl_addr == 12'h2AA && fl_wdata == 8'h55) ms = 6; else begin proto_err++; ms = 0; end
                  6: begin
                     if (fl_addr == 12'h555 && fl_wdata == 8'h10) begin
                        for (int k = 0; k < 64; k++) mem[k] = 8'hFF;
                        tgt = 8'hFF; busy_left = cfg_busy; hang = 0; rsince = 0;
                     end else proto_err++;
                     ms = 0;
                  end
                  default: begin proto_err++; ms = 0; end
               endcase
            end
         end
         if (fl_re) begin
            if (busy_left != 0 || hang) begin
               fl_rdata <= {~tgt[7], tog, (cfg_dq5 != 255 && rsince >= cfg_dq5), 5'b0};
               tog = ~tog;
               rsince++;
               if (!hang) busy_left--;
            end else begin
               fl_rdata <= mem[fl_addr[5:0]];
            end
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   int done_w0, done_rst0, done_err0;
   logic res_pass;
   logic [AW-1:0] res_addr;

   task automatic run_op(input logic er, input logic tg, input logic [11:0] b, input logic [12:0] l,
                         input bit poke, input string req);
      int cyc;
      done_w0 = wr_cnt; done_rst0 = rst_cnt; done_err0 = proto_err;
      @(negedge clk);
      req_valid = 1'b1; req_erase = er; req_toggle = tg; req_base = b; req_len = l;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 3) begin
            req_valid = 1'b1; req_base = 12'h03F; req_len = 13'd1; req_toggle = 1'b1;
         end else req_valid = 1'b0;
      end
      req_valid = 1'b0;
      chk(done, req, "done reached", int'(done), 1);
      res_pass = pass;
      res_addr = fail_addr;
      @(negedge clk);
      chk(!done && !busy, "R6", "done single cycle", int'(done), 0);
   endtask

   task automatic preset(input logic [7:0] v);
      for (int k = 0; k < 64; k++) mem[k] = v;
   endtask

   task automatic cmp_mem(input logic er, input logic [11:0] b, input int nwr, input string req);
      int bad; int first;
      logic [7:0] e;
      bad = 0; first = -1;
      for (int k = 0; k < 64; k++) begin
         e = 8'hFF;
         if (!er && k >= b && k < b + nwr) e = pat(12'(k - b), seed);
         if (mem[k] !== e) begin bad++; if (first < 0) first = k; end
      end
      chk(bad == 0, req, "memory image mismatches", bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      preset(8'hFF);
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!busy && !done, "R10", "busy/done in reset", int'({busy, done}), 0);
      chk(!fl_we && !fl_re, "R10", "strobes in reset", int'({fl_we, fl_re}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !fl_we && !fl_re, "R10", "idle after reset", int'({busy, fl_we, fl_re}), 0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         int nb; int ew;
         seed = 8'(v * 17 + 3);
         preset(VECS[v].erase ? 8'h00 : 8'hFF);
         cfg_busy = int'(VECS[v].busy);
         cfg_dq5  = int'(VECS[v].dq5_at);
         cfg_hang = VECS[v].hang_addr;
         run_op(VECS[v].erase, VECS[v].tog, VECS[v].base, VECS[v].len, 1'b0, "R6");
         chk(res_pass == VECS[v].exp_pass, VECS[v].exp_pass ? "R2" : "R9", "pass flag", int'(res_pass), int'(VECS[v].exp_pass));
         if (VECS[v].erase) begin
            nb = 0; ew = 6;
            chk(wr_cnt - done_w0 == 6, "R7", "wipe write count", wr_cnt - done_w0, 6);
         end else if (VECS[v].exp_pass) begin
            nb = int'(VECS[v].len); ew = 4 * nb;
            chk(wr_cnt - done_w0 == ew, "R1", "program write count", wr_cnt - done_w0, ew);
         end else begin
            nb = int'(VECS[v].hang_addr - VECS[v].base) + 1; ew = 4 * nb + 1;
            chk(wr_cnt - done_w0 == ew, "R9", "write count with reset", wr_cnt - done_w0, ew);
            chk(res_addr == VECS[v].hang_addr, "R9", "fail_addr", int'(res_addr), int'(VECS[v].hang_addr));
         end
         chk(rst_cnt - done_rst0 == (VECS[v].exp_pass ? 0 : 1), "R9", "reset writes", rst_cnt - done_rst0, VECS[v].exp_pass ? 0 : 1);
         chk(proto_err == done_err0, "R1", "command order errors", proto_err - done_err0, 0);
         cmp_mem(VECS[v].erase, VECS[v].base, nb, VECS[v].erase ? "R7" : "R6");
      end

      // R6 zero-length request
      seed = 8'h41;
      preset(8'hFF);
      run_op(1'b0, 1'b0, 12'h010, 13'd0, 1'b0, "R6");
      chk(res_pass == 1'b1, "R6", "len0 pass", int'(res_pass), 1);
      chk(wr_cnt == done_w0, "R6", "len0 writes", wr_cnt - done_w0, 0);

      // R11 start ignored while busy
      seed = 8'h77;
      preset(8'hFF);
      cfg_busy = 6; cfg_dq5 = 255; cfg_hang = 12'hFFF;
      run_op(1'b0, 1'b0, 12'h010, 13'd2, 1'b1, "R11");
      chk(res_pass == 1'b1, "R11", "pass with stray start", int'(res_pass), 1);
      chk(wr_cnt - done_w0 == 8, "R11", "write count with stray start", wr_cnt - done_w0, 8);
      chk(mem[63] == 8'hFF, "R11", "stray target untouched", int'(mem[63]), 8'hFF);
      cmp_mem(1'b0, 12'h010, 2, "R11");
      repeat (4) @(negedge clk);
      chk(!busy, "R11", "no second run", int'(busy), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule